// File: doc/BRIEF.md
# GPIO Bank Register Block

This block holds the software-visible state of one bank of general purpose pins: the output data word, the per-pin direction bits and the per-pin output-enable bits. It also shows software the live level on every pin of the bank. A simple synchronous register bus reaches the block through an address, a write strobe, a write word and a read word. A read is combinational from the address. A write takes effect at the clock edge on which the strobe is high.

Software can change the output data in two ways. It can write the whole word in one access. It can also issue a masked write to either the lower or the upper half of the bank. In a masked write, the top half of the bus word is a per-bit guard: a guard bit at 1 keeps the output bit as it is. The bottom half of the bus word carries the new values. A pin drives only when its direction bit and its enable bit are both 1.

Incoming pin levels pass through a two-stage synchronizer. The synchronized value feeds the read-only level register and is also offered on a separate output for an interrupt detector that lives outside this block. The bank width is a parameter, so a bank narrower than 32 pins can be built. An incoming reset is applied at once and released in step with the clock.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted and after it is released, and before any write, every register reads as zero, `pad_out` is zero and `pad_oe` is zero, so every pin is an input with its driver off.
- R2: A write to address 0 loads bus bits [PIN_W-1:0] into the output data register in one access. A read of address 0 returns the last value written to the output data register, never the pin level, and `pad_out` carries that same value.
- R3: A write to address 1 is a masked write to the lower half. For each i in 0..15, output bit i takes bus bit i when bus bit 16+i is 0, and keeps its value when bus bit 16+i is 1. Output bits 16 and above are unchanged.
- R4: A write to address 2 is a masked write to the upper half. For each j in 0..15 with 16+j < PIN_W, output bit 16+j takes bus bit j when bus bit 16+j is 0, and keeps its value when bus bit 16+j is 1. Output bits 0..15 are unchanged.
- R5: Address 3 is the direction register and address 4 is the output-enable register. Each loads bus bits [PIN_W-1:0] on a write and reads back what was stored.
- R6: `pad_oe[i]` is 1 exactly when direction bit i and output-enable bit i are both 1. A 0 in either bit turns the driver off.
- R7: Address 5 reads the pin levels after a two-flop synchronizer. A change on `pad_in` shows up in that read and on `pad_seen` after the second rising clock edge, and not after the first. Writes to address 5 change nothing.
- R8: Bus bits at PIN_W and above read as zero and are ignored on writes. Reads of addresses 1, 2, 6 and 7 return zero, and writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, combinational from `bus_addr` |
| pad_in | input | PIN_W | Raw levels seen on the pins |
| pad_out | output | PIN_W | Output values to the pin drivers |
| pad_oe | output | PIN_W | Per-pin driver enable |
| pad_seen | output | PIN_W | Synchronized pin levels for the interrupt detector |

## Verification
The assertions assume that the bus carries at most one write per clock. They also assume that `pad_in` is a level that is settled at the sampling edge, so that each synchronizer stage copies the stage before it. The bench drives all inputs on the falling clock edge. It therefore makes one write per strobe cycle and holds every pin level stable across each rising edge. It checks the synchronizer latency by changing `pad_in` once and reading both before and after the second rising edge. The bench builds a 22-pin bank, so both the ignored upper bus bits and the partial upper half are exercised.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;
  localparam int ADDR_W = 3;

  // Register word map. The masked-write encodings depend on these positions.
  typedef enum logic [ADDR_W-1:0] {
    SEL_OUT  = 3'd0,
    SEL_MLO  = 3'd1,
    SEL_MHI  = 3'd2,
    SEL_DIR  = 3'd3,
    SEL_EN   = 3'd4,
    SEL_LVL  = 3'd5,
    SEL_RSV6 = 3'd6,
    SEL_RSV7 = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = raw_in;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

  // Checker: count edges since reset so the latency check never looks before it.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_q != 2'd3) begin
      warm_q <= warm_q + 2'd1;
    end
  end

  generate
    if (STAGES == 2) begin : g_lat_chk
      // R7
      sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (sync_out == $past(raw_in, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = wr_en;
    q_d  = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_d;
    end
  end

  // R5
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == $past(wr_val)));

  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_full,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [W-1:0]     q
);

  logic [W-1:0] q_d;
  logic         q_en;

  assign q_en = wr_full | wr_lo | wr_hi;

  // Per-bit next value: the full word wins, else the half-word with its guard.
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < HALF_W) begin : g_lo
        always_comb begin
          if (wr_full) begin
            q_d[i] = wdata[i];
          end else if (wr_lo && !wdata[HALF_W+i]) begin
            q_d[i] = wdata[i];
          end else begin
            q_d[i] = q[i];
          end
        end
      end else begin : g_hi
        always_comb begin
          if (wr_full) begin
            q_d[i] = wdata[i];
          end else if (wr_hi && !wdata[i]) begin
            q_d[i] = wdata[i-HALF_W];
          end else begin
            q_d[i] = q[i];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_d;
    end
  end

  // R2
  full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |=> (q == $past(wdata[W-1:0])));

  // R3
  lo_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_full && (wdata[BUS_W-1:HALF_W] == '1)) |=> $stable(q));

  // R4
  hi_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_full && (wdata[BUS_W-1:HALF_W] == '1)) |=> $stable(q));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |=> $stable(q));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe,
  output logic [PIN_W-1:0]  pad_seen
);

  logic             rst_n;
  reg_sel_e         sel;
  logic             wr_out, wr_lo, wr_hi, wr_dir, wr_en;
  logic [PIN_W-1:0] out_q, dir_q, en_q;
  logic [BUS_W-1:0] rdata_d;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  assign sel = reg_sel_e'(bus_addr);

  always_comb begin
    wr_out = bus_we && (sel == SEL_OUT);
    wr_lo  = bus_we && (sel == SEL_MLO);
    wr_hi  = bus_we && (sel == SEL_MHI);
    wr_dir = bus_we && (sel == SEL_DIR);
    wr_en  = bus_we && (sel == SEL_EN);
  end

  gpio_out_reg #(.W(PIN_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_full (wr_out),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wdata   (bus_wdata),
    .q       (out_q)
  );

  gpio_ctrl_reg #(.W(PIN_W)) u_dir (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_dir),
    .wr_val (bus_wdata[PIN_W-1:0]),
    .q      (dir_q)
  );

  gpio_ctrl_reg #(.W(PIN_W)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_val (bus_wdata[PIN_W-1:0]),
    .q      (en_q)
  );

  gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pad_in),
    .sync_out (pad_seen)
  );

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_OUT: rdata_d[PIN_W-1:0] = out_q;
      SEL_DIR: rdata_d[PIN_W-1:0] = dir_q;
      SEL_EN:  rdata_d[PIN_W-1:0] = en_q;
      SEL_LVL: rdata_d[PIN_W-1:0] = pad_seen;
      default: rdata_d = '0;
    endcase
  end

  assign bus_rdata = rdata_d;
  assign pad_out   = out_q;
  assign pad_oe    = dir_q & en_q;

  // R8
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == SEL_RSV6) || (sel == SEL_RSV7) || (sel == SEL_MLO) || (sel == SEL_MHI))
      |-> (bus_rdata == '0));

  generate
    if (PIN_W < BUS_W) begin : g_pad_chk
      // R8
      upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PIN_W] == '0);
    end
  endgenerate

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

  localparam int W = 22;
  localparam logic [31:0] IMPL = (32'h1 << W) - 32'h1;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [W-1:0] pad_in, pad_out, pad_oe, pad_seen;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_out, m_dir, m_en;

  always #4 clk = ~clk;

  gpio_bank #(.PIN_W(W)) uut (
    .clk(clk), .arst_n(arst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_seen(pad_seen)
  );

  function automatic logic [31:0] mix(input int k);
    logic [31:0] v;
    v = 32'(k) * 32'h9E37_79B1;
    v = v ^ (v >> 13) ^ (32'(k) << 21);
    return v * 32'h85EB_CA6B;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] v;
    rd(3'd0, v); chk(req, v, m_out);
    rd(3'd3, v); chk(req, v, m_dir);
    rd(3'd4, v); chk(req, v, m_en);
    chk(req, 32'(pad_out), m_out);
    chk(req, 32'(pad_oe), m_dir & m_en);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d, g, lvl;
    arst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    m_out = '0; m_dir = '0; m_en = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", 32'(pad_oe), 32'h0);
    chk("R1", 32'(pad_out), 32'h0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release, R8 reserved reads
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1", v, 32'h0);
    end
    chk("R1", 32'(pad_oe), 32'h0);

    // R2 walking ones and mixed words, R8 upper bits ignored
    for (int k = 0; k < 40; k++) begin
      d = (k < 32) ? (32'h1 << k) : mix(k);
      wr(3'd0, d);
      m_out = d & IMPL;
      check_regs("R2");
    end

    // R3 lower masked writes
    for (int k = 0; k < 48; k++) begin
      d = mix(k + 200);
      g = d >> 16;
      wr(3'd1, d);
      m_out = (m_out & ~32'hFFFF) | (m_out & g & 32'hFFFF) | (d & ~g & 32'hFFFF);
      check_regs("R3");
    end
    wr(3'd1, 32'h0000_A5C3);
    m_out = (m_out & ~32'hFFFF) | 32'h0000_A5C3;
    check_regs("R3");

    // R4 upper masked writes
    for (int k = 0; k < 48; k++) begin
      d = mix(k + 500);
      g = d >> 16;
      wr(3'd2, d);
      m_out = ((m_out & 32'hFFFF) | (m_out & (g << 16)) | ((d << 16) & ~(g << 16))) & IMPL;
      check_regs("R4");
    end
    wr(3'd2, 32'hFFFF_FFFF);
    check_regs("R4");

    // R8 masked addresses read zero
    rd(3'd1, v); chk("R8", v, 32'h0);
    rd(3'd2, v); chk("R8", v, 32'h0);

    // R5 and R6 direction/enable combinations
    for (int k = 0; k < 32; k++) begin
      d = mix(k + 900); g = mix(k + 1300);
      wr(3'd3, d); m_dir = d & IMPL;
      wr(3'd4, g); m_en = g & IMPL;
      check_regs("R5");
      chk("R6", 32'(pad_oe), m_dir & m_en);
    end
    wr(3'd3, 32'h0); m_dir = '0;
    wr(3'd4, 32'hFFFF_FFFF); m_en = IMPL;
    chk("R6", 32'(pad_oe), 32'h0);
    wr(3'd3, 32'hFFFF_FFFF); m_dir = IMPL;
    chk("R6", 32'(pad_oe), IMPL);
    wr(3'd4, 32'h0); m_en = '0;
    chk("R6", 32'(pad_oe), 32'h0);

    // R7 synchronizer latency
    lvl = '0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      d = mix(k + 1700) & IMPL;
      pad_in = d[W-1:0];
      @(negedge clk);
      rd(3'd5, v); chk("R7", v, lvl);
      chk("R7", 32'(pad_seen), lvl);
      @(negedge clk);
      rd(3'd5, v); chk("R7", v, d);
      chk("R7", 32'(pad_seen), d);
      lvl = d;
    end
    // R2 data read is not the pin level
    rd(3'd0, v); chk("R2", v, m_out);

    // R7 write to level address ignored; R8 reserved writes ignored
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R7", v, lvl);
    check_regs("R7");
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h1234_5678);
    check_regs("R8");
    rd(3'd6, v); chk("R8", v, 32'h0);
    rd(3'd7, v); chk("R8", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule